// File: doc/BRIEF.md
# Configurable Per-Pin I/O Port

This block is a general-purpose I/O port that sits on a microcontroller's host bus. Every pin chooses on its own what it drives. It can drive a bit of its data-out register, a bit of the low address byte that was captured on the address-latch-enable strobe, a bit from the programmable logic array, or a chip-select line from an external decoder. A pin drives only when its direction bit is set or when the array's shared output-enable is high. Otherwise it stays an input. Pins on one port can therefore serve different functions at the same time.

The host writes registers through a single-cycle write strobe that is qualified by chip select. It reads them back through one read path that returns exactly one source per access. The sources are the data-out, direction and source-select registers, the array outputs, and the synchronized pin levels. Read data appears on the cycle after the read strobe and holds until the next read. A parameter removes the software-written source-select register. A port built that way takes its per-pin selection from a static configuration input.

Top module: `cfg_io_port`

## Requirements
- R1: Reset clears data-out, direction, source-select, the address latch, the pin synchronizer and the read data. After reset every pin has `pin_oe` low, `pin_out` is 0 and every register reads back as 0.
- R2: A write occurs only when `host_cs` and `host_wr` are both high at a clock edge. Offset 0 loads data-out and offset 1 loads direction, and the new value shows from the next cycle. A write strobe without `host_cs` changes nothing.
- R3: The 16-bit source-select register is written one byte at a time. Offset 2 holds pins 0 to 3 and offset 5 holds pins 4 to 7. Pin i uses bits [2i+1:2i].
- R4: Each pin's 2-bit source select drives `pin_out[i]` as follows: 00 takes data-out bit i, 01 takes latched address bit i, 10 takes `array_out[i]` and 11 takes `chip_sel[i]`. Pins are selected independently of each other.
- R5: `pin_oe[i]` is high exactly when direction bit i is 1 or `array_oe` is high.
- R6: The address latch loads `bus_addr` on every clock edge where `ale` is high. It holds its value while `ale` is low.
- R7: A read occurs when `host_cs` and `host_rd` are high at an edge, and `host_rdata` shows the result from the next cycle. The offsets are: 0 data-out, 1 direction, 2 select low byte, 3 `array_out`, 4 synchronized pins, 5 select high byte, 6 and 7 zero. Without a read, `host_rdata` keeps its last value.
- R8: Pin levels pass through two synchronizing flops before the read path. A read whose strobe falls on the first clock after a pin changes still returns the old level. A read issued two or more cycles later returns the new level.
- R9: Writes to offsets 3, 4, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host chip select qualifying reads and writes |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| ale | input | 1 | Address-latch-enable strobe |
| bus_addr | input | 8 | Low address byte from the bus |
| array_out | input | 8 | Logic-array output bits, one per pin |
| chip_sel | input | 8 | External chip-select lines, one per pin |
| array_oe | input | 1 | Shared output enable from the logic array |
| static_sel | input | 16 | Fixed per-pin source select, used when the select register is absent |
| pin_in | input | 8 | Live pin levels |
| pin_out | output | 8 | Value each pin drives |
| pin_oe | output | 8 | Per-pin tri-state enable |

## Verification
The bench programs a mixed select pattern in which neighbouring pins take different sources, and sets the data so that every pin reads all-ones in one pattern and all-zeros in the next. A design that swaps the select bit order or uses one select for all pins then shows wrong bits. It writes a chip-select-less strobe and writes to every read-only offset, then reads back each register. A decoder that ignores `host_cs` or folds offsets onto their neighbours would corrupt a register that the bench can see. It moves the bus address while `ale` is low and expects the pins to hold the old address. It also reads a pin one cycle after it changes and expects the old level. A transparent latch or a single-flop synchronizer would leak the new value early. A mid-run reset must return every pin to an input.

// File: rtl/cfg_io_port_pkg.sv
package cfg_io_port_pkg;

    localparam int HOST_DW = 8;
    localparam int HOST_AW = 3;

    typedef enum logic [1:0] {
        SRC_DATA  = 2'b00,
        SRC_ADDR  = 2'b01,
        SRC_ARRAY = 2'b10,
        SRC_CSEL  = 2'b11
    } pin_src_e;

    localparam logic [HOST_AW-1:0] OFF_DOUT    = 3'd0;
    localparam logic [HOST_AW-1:0] OFF_DIR     = 3'd1;
    localparam logic [HOST_AW-1:0] OFF_SEL_LO  = 3'd2;
    localparam logic [HOST_AW-1:0] OFF_ARRAY   = 3'd3;
    localparam logic [HOST_AW-1:0] OFF_PINS    = 3'd4;
    localparam logic [HOST_AW-1:0] OFF_SEL_HI  = 3'd5;

endpackage

// File: rtl/port_host_regs.sv
module port_host_regs
    import cfg_io_port_pkg::*;
#(
    parameter int W        = 8,
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [HOST_AW-1:0]   addr,
    input  logic [HOST_DW-1:0]   wdata,
    input  logic [2*W-1:0]       static_sel,
    output logic [W-1:0]         dout_q,
    output logic [W-1:0]         dir_q,
    output logic [2*W-1:0]       sel
);
    localparam int CW = 2 * W;

    typedef struct packed {
        logic [W-1:0]  dout;
        logic [W-1:0]  dir;
        logic [CW-1:0] ctrl;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [2*HOST_DW-1:0] ctrl_wide;

    always_comb begin
        regs_d    = regs_q;
        ctrl_wide = '0;
        ctrl_wide[CW-1:0] = regs_q.ctrl;
        if (wr_en) begin
            case (addr)
                OFF_DOUT:   regs_d.dout = wdata[W-1:0];
                OFF_DIR:    regs_d.dir  = wdata[W-1:0];
                OFF_SEL_LO: ctrl_wide[HOST_DW-1:0] = wdata;
                OFF_SEL_HI: ctrl_wide[2*HOST_DW-1:HOST_DW] = wdata;
                default:    ;
            endcase
        end
        if (HAS_CTRL) begin
            regs_d.ctrl = ctrl_wide[CW-1:0];
        end else begin
            regs_d.ctrl = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign dout_q = regs_q.dout;
    assign dir_q  = regs_q.dir;

    generate
        if (HAS_CTRL) begin : g_soft_sel
            logic unused_static;
            assign unused_static = ^static_sel;
            assign sel = regs_q.ctrl;
        end else begin : g_fixed_sel
            logic unused_ctrl;
            assign unused_ctrl = ^regs_q.ctrl;
            assign sel = static_sel;
        end
    endgenerate

    AST_DOUT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_DOUT) |=> (dout_q == $past(wdata[W-1:0]))); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dout_q) && $stable(dir_q))); // R2
    AST_RO_OFFSET_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFF_ARRAY || addr == OFF_PINS || addr == 3'd6 || addr == 3'd7))
        |=> $stable(regs_q)); // R9

endmodule

// File: rtl/port_addr_latch.sv
module port_addr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale,
    input  logic [W-1:0] bus_addr,
    output logic [W-1:0] laddr_q
);
    typedef struct packed {
        logic [W-1:0] addr;
    } latch_t;

    latch_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (ale) lat_d.addr = bus_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign laddr_q = lat_q.addr;

    AST_ALE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (laddr_q == $past(bus_addr))); // R6
    AST_ALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(laddr_q)); // R6

endmodule

// File: rtl/port_out_mux.sv
module port_out_mux
    import cfg_io_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2*W-1:0] sel,
    input  logic [W-1:0]   dout,
    input  logic [W-1:0]   laddr,
    input  logic [W-1:0]   array_out,
    input  logic [W-1:0]   chip_sel,
    input  logic [W-1:0]   dir,
    input  logic           array_oe,
    output logic [W-1:0]   pin_out,
    output logic [W-1:0]   pin_oe
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            pin_src_e src;
            assign src = pin_src_e'(sel[2*i +: 2]);

            always_comb begin
                case (src)
                    SRC_DATA:  pin_out[i] = dout[i];
                    SRC_ADDR:  pin_out[i] = laddr[i];
                    SRC_ARRAY: pin_out[i] = array_out[i];
                    SRC_CSEL:  pin_out[i] = chip_sel[i];
                    default:   pin_out[i] = dout[i];
                endcase
            end

            assign pin_oe[i] = dir[i] | array_oe;
        end
    endgenerate

endmodule

// File: rtl/port_readback.sv
module port_readback
    import cfg_io_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [HOST_AW-1:0] addr,
    input  logic [W-1:0]       dout,
    input  logic [W-1:0]       dir,
    input  logic [2*W-1:0]     sel,
    input  logic [W-1:0]       array_out,
    input  logic [W-1:0]       pin_in,
    output logic [HOST_DW-1:0] rdata
);
    localparam int CW = 2 * W;

    typedef struct packed {
        logic [W-1:0]       sync1;
        logic [W-1:0]       sync2;
        logic [HOST_DW-1:0] rdata;
        logic [1:0]         age;
    } rb_t;

    rb_t rb_d, rb_q;
    logic [2*HOST_DW-1:0] sel_wide;

    function automatic logic [HOST_DW-1:0] widen(input logic [W-1:0] v);
        logic [HOST_DW-1:0] r;
        r = '0;
        r[W-1:0] = v;
        return r;
    endfunction

    always_comb begin
        rb_d       = rb_q;
        sel_wide   = '0;
        sel_wide[CW-1:0] = sel;
        rb_d.sync1 = pin_in;
        rb_d.sync2 = rb_q.sync1;
        rb_d.age   = (rb_q.age == 2'd3) ? rb_q.age : rb_q.age + 2'd1;
        if (rd_en) begin
            case (addr)
                OFF_DOUT:   rb_d.rdata = widen(dout);
                OFF_DIR:    rb_d.rdata = widen(dir);
                OFF_SEL_LO: rb_d.rdata = sel_wide[HOST_DW-1:0];
                OFF_ARRAY:  rb_d.rdata = widen(array_out);
                OFF_PINS:   rb_d.rdata = widen(rb_q.sync2);
                OFF_SEL_HI: rb_d.rdata = sel_wide[2*HOST_DW-1:HOST_DW];
                default:    rb_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign rdata = rb_q.rdata;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R7
    AST_UNUSED_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 3'd6 || addr == 3'd7)) |=> (rdata == '0)); // R7
    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFF_PINS && rb_q.age == 2'd3)
        |=> (rdata[W-1:0] == $past(pin_in, 3))); // R8

endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
    import cfg_io_port_pkg::*;
#(
    parameter int W        = 8,
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cs,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic               ale,
    input  logic [W-1:0]       bus_addr,
    input  logic [W-1:0]       array_out,
    input  logic [W-1:0]       chip_sel,
    input  logic               array_oe,
    input  logic [2*W-1:0]     static_sel,
    input  logic [W-1:0]       pin_in,
    output logic [W-1:0]       pin_out,
    output logic [W-1:0]       pin_oe
);
    logic           wr_en;
    logic           rd_en;
    logic [W-1:0]   dout_q;
    logic [W-1:0]   dir_q;
    logic [W-1:0]   laddr_q;
    logic [2*W-1:0] sel;

    assign wr_en = host_cs & host_wr;
    assign rd_en = host_cs & host_rd;

    port_host_regs #(.W(W), .HAS_CTRL(HAS_CTRL)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .static_sel (static_sel),
        .dout_q     (dout_q),
        .dir_q      (dir_q),
        .sel        (sel)
    );

    port_addr_latch #(.W(W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .bus_addr (bus_addr),
        .laddr_q  (laddr_q)
    );

    port_out_mux #(.W(W)) u_mux (
        .sel       (sel),
        .dout      (dout_q),
        .laddr     (laddr_q),
        .array_out (array_out),
        .chip_sel  (chip_sel),
        .dir       (dir_q),
        .array_oe  (array_oe),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    port_readback #(.W(W)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .addr      (host_addr),
        .dout      (dout_q),
        .dir       (dir_q),
        .sel       (sel),
        .array_out (array_out),
        .pin_in    (pin_in),
        .rdata     (host_rdata)
    );

    AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe == (dir_q | {W{array_oe}})); // R5

    generate
        for (genvar i = 0; i < W; i++) begin : g_chk
            AST_ADDR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
                (sel[2*i +: 2] == SRC_ADDR) |-> (pin_out[i] == laddr_q[i])); // R4
            AST_CSEL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
                (sel[2*i +: 2] == SRC_CSEL) |-> (pin_out[i] == chip_sel[i])); // R4
        end
    endgenerate

endmodule

// File: tb/tb_cfg_io_port.sv
module tb_cfg_io_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       ale = 1'b0;
    logic [7:0] bus_addr = '0, array_out = '0, chip_sel = '0, pin_in = '0;
    logic       array_oe = 1'b0;
    logic [15:0] static_sel = '0;
    logic [7:0] pin_out, pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_io_port dut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
        .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .ale(ale), .bus_addr(bus_addr),
        .array_out(array_out), .chip_sel(chip_sel), .array_oe(array_oe),
        .static_sel(static_sel), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe)
    );

    typedef struct packed {
        logic [15:0] ctrl;
        logic [7:0]  dout;
        logic [7:0]  dir;
        logic        oe;
        logic [7:0]  arr;
        logic [7:0]  cs;
        logic [7:0]  adr;
        logic [7:0]  exp_out;
        logic [7:0]  exp_oe;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 8'hA5, 8'hFF, 1'b0, 8'h3C, 8'h0F, 8'h81, 8'hA5, 8'hFF},
        '{16'h5555, 8'h00, 8'h0F, 1'b0, 8'h00, 8'h00, 8'hC3, 8'hC3, 8'h0F},
        '{16'hAAAA, 8'hFF, 8'h00, 1'b1, 8'h96, 8'h00, 8'h00, 8'h96, 8'hFF},
        '{16'hFFFF, 8'h00, 8'hF0, 1'b0, 8'hFF, 8'h5A, 8'hFF, 8'h5A, 8'hF0},
        '{16'hE4E4, 8'h11, 8'hA5, 1'b0, 8'h44, 8'h88, 8'h22, 8'hFF, 8'hA5},
        '{16'hE4E4, 8'hEE, 8'h5A, 1'b0, 8'hBB, 8'h77, 8'hDD, 8'h00, 8'h5A}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_cs = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_cs = 1'b1; host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_cs = 1'b0; host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic latch_addr(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0; bus_addr = ~a;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [7:0] r;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1 state held in reset
        chk("R1 oe in reset", pin_oe, 8'h00);
        chk("R1 out in reset", pin_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after reset", host_rdata, 8'h00);
        rd(3'd0, r); chk("R1 dout reads 0", r, 8'h00);
        rd(3'd1, r); chk("R1 dir reads 0", r, 8'h00);
        rd(3'd2, r); chk("R1 sel lo reads 0", r, 8'h00);
        rd(3'd5, r); chk("R1 sel hi reads 0", r, 8'h00);

        // table-driven: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, VECS[v].dout);
            wr(3'd1, VECS[v].dir);
            wr(3'd2, VECS[v].ctrl[7:0]);
            wr(3'd5, VECS[v].ctrl[15:8]);
            latch_addr(VECS[v].adr);
            @(negedge clk);
            array_out = VECS[v].arr; chip_sel = VECS[v].cs; array_oe = VECS[v].oe;
            @(negedge clk);
            chk("R4 R6 pin_out vector", pin_out, VECS[v].exp_out);
            chk("R5 pin_oe vector", pin_oe, VECS[v].exp_oe);
            rd(3'd0, r); chk("R2 R7 dout readback", r, VECS[v].dout);
            rd(3'd1, r); chk("R2 R7 dir readback", r, VECS[v].dir);
            rd(3'd2, r); chk("R3 R7 sel lo readback", r, VECS[v].ctrl[7:0]);
            rd(3'd5, r); chk("R3 R7 sel hi readback", r, VECS[v].ctrl[15:8]);
            rd(3'd3, r); chk("R7 array readback", r, VECS[v].arr);
        end

        // R2 strobe without chip select
        @(negedge clk);
        host_cs = 1'b0; host_wr = 1'b1; host_addr = 3'd0; host_wdata = 8'h3C;
        @(negedge clk);
        host_wr = 1'b0;
        rd(3'd0, r); chk("R2 write without cs ignored", r, 8'hEE);

        // R9 read-only offsets
        wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd0, r); chk("R9 dout untouched", r, 8'hEE);
        rd(3'd1, r); chk("R9 dir untouched", r, 8'h5A);
        rd(3'd2, r); chk("R9 sel lo untouched", r, 8'hE4);
        rd(3'd5, r); chk("R9 sel hi untouched", r, 8'hE4);
        chk("R9 pins untouched", pin_out, 8'h00);

        // R6 latch holds while ale low, then captures
        wr(3'd2, 8'h55); wr(3'd5, 8'h55);
        @(negedge clk);
        chk("R4 all pins take latched addr", pin_out, 8'hDD);
        bus_addr = 8'h3C;
        repeat (2) @(negedge clk);
        chk("R6 hold with ale low", pin_out, 8'hDD);
        latch_addr(8'h3C);
        chk("R6 capture with ale high", pin_out, 8'h3C);

        // R7 hold between reads and unused offsets
        rd(3'd1, held);
        wr(3'd1, 8'h0F);
        @(negedge clk);
        chk("R7 rdata held without read", host_rdata, held);
        rd(3'd6, r); chk("R7 offset 6 zero", r, 8'h00);
        rd(3'd7, r); chk("R7 offset 7 zero", r, 8'h00);

        // R8 two-flop synchronizer latency
        @(negedge clk);
        pin_in = 8'hA7;
        rd(3'd4, r); chk("R8 early read sees old level", r, 8'h00);
        rd(3'd4, r); chk("R8 later read sees new level", r, 8'hA7);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset oe", pin_oe, 8'h00);
        chk("R1 mid-run reset out", pin_out, 8'h00);
        chk("R1 mid-run reset rdata", host_rdata, 8'h00);
        rst_n = 1'b1;
        rd(3'd1, r); chk("R1 dir cleared", r, 8'h00);

        summary();
    end

endmodule